// File: doc/BRIEF.md
# On/Off Delay Timer with Pause

This block filters a single binary input so that its output follows the input only after each change has lasted long enough. A rise of the input must persist for a programmable number of time-base ticks before the output goes high. A fall must persist for a second, independently programmed number of ticks before the output goes low. The time base is a single-cycle tick enable, so the same block serves microsecond or millisecond delays depending on how often the tick pulses.

Two control inputs act on a running delay. A pause input freezes the elapsed count without discarding it, and timing resumes where it stopped once pause is released. A cancel input aborts any delay in progress and forces the output low. After a cancel the block waits for the input to be seen low and then high again before it starts a new on-delay. One elapsed-tick counter serves both delay phases, under a four-phase state machine.

Top module: `onoff_delay_timer`

## Requirements
- R1: While `rst` is high the output `level_o` is low. After `rst` falls, a `sig_i` that is already high counts as a fresh rise on the first edge.
- R2: An on-delay starts on the clock edge that samples `sig_i` high after a low sample while the output is low and no delay runs. A qualifying tick is a cycle with `tick_i`=1 and `pause_i`=0, and ticks sampled on the starting edge do not count. `level_o` goes high right after the edge that samples the `on_ticks_i`-th qualifying tick. With a tick on every cycle that is `on_ticks_i`+1 edges after the rise. When `on_ticks_i`=0 it goes high after the starting edge itself.
- R3: An off-delay starts on the edge that first samples `sig_i` low while the output is high and steady. `level_o` goes low right after the edge that samples the `off_ticks_i`-th qualifying tick. When `off_ticks_i`=0 it goes low right after that starting edge.
- R4: A tick sampled with `pause_i`=1 is not counted, and the elapsed count is kept. With `on_ticks_i`=5, a tick every cycle and 4 paused cycles inside the on-delay, the output rises 10 edges after the input rise.
- R5: If `sig_i` is sampled low during an on-delay, the output stays low and the elapsed count is discarded. A later rise needs the full on-delay again.
- R6: `cancel_i`=1 forces the output low and aborts any delay, taking priority over `pause_i`. The output stays low until `sig_i` has been sampled low and then rises again.
- R7: If `sig_i` is sampled high again during an off-delay, the output stays high and the off-delay count is discarded. The next fall needs the full off-delay.
- R8: Cycles with `tick_i`=0 are not counted. With no ticks at all, a held-high input never raises the output when `on_ticks_i` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Single-cycle time-base enable |
| pause_i | input | 1 | Freeze elapsed delay time |
| cancel_i | input | 1 | Abort running delay, force output low |
| sig_i | input | 1 | Binary input to be delayed |
| on_ticks_i | input | CNT_W | Rise delay in ticks |
| off_ticks_i | input | CNT_W | Fall delay in ticks |
| level_o | output | 1 | Delayed output |

## Verification
Directed patterns measure the number of edges from an input change to the output change. They cover nonzero and zero delays in both directions, so an off-by-one in the start edge or in the compare is caught. A pause window inside an on-delay tells freezing apart from clearing, and a drop during the on-delay tells discarding apart from keeping. A cancel held together with pause checks priority and re-arming, and a re-rise during the off-delay checks the return to a steady high. A long random run with a sparse tick and random pause and cancel is compared on every clock against a behavioural model.

// File: rtl/odt_pkg.sv
package odt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ARMING  = 2'd1,
        PH_HELD    = 2'd2,
        PH_RELEASE = 2'd3
    } phase_e;

    function automatic logic phase_drives_high(input phase_e ph);
        return (ph == PH_HELD) || (ph == PH_RELEASE);
    endfunction

    function automatic logic phase_is_timing(input phase_e ph);
        return (ph == PH_ARMING) || (ph == PH_RELEASE);
    endfunction

endpackage

// File: rtl/odt_tick_gate.sv
module odt_tick_gate (
    input  logic tick_i,
    input  logic pause_i,
    output logic qual_o
);
    always_comb qual_o = tick_i & ~pause_i;
endmodule

// File: rtl/odt_tick_counter.sv
module odt_tick_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_nxt;

    always_comb begin
        cnt_nxt = {1'b0, cnt_q} + (W+1)'(1);
        done_o  = inc_i && (cnt_nxt >= {1'b0, limit_i});
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= '0;
        else if (inc_i)
            cnt_q <= cnt_nxt[W-1:0];
    end

    // R4: with neither clear nor increment the elapsed count is kept
    assert_count_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !inc_i) |=> $stable(cnt_q));

endmodule

// File: rtl/odt_phase_fsm.sv
module odt_phase_fsm
    import odt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cancel_i,
    input  logic   sig_i,
    input  logic   qual_i,
    input  logic   on_zero_i,
    input  logic   off_zero_i,
    input  logic   done_i,
    output logic   cnt_clr_o,
    output logic   cnt_inc_o,
    output phase_e phase_o,
    output logic   level_o
);
    phase_e phase_q, phase_d;
    logic   sig_d;
    logic   rise, running;

    always_comb begin
        rise    = sig_i & ~sig_d;
        running = !cancel_i &&
                  (((phase_q == PH_ARMING)  &&  sig_i) ||
                   ((phase_q == PH_RELEASE) && !sig_i));
        cnt_inc_o = running && qual_i;
        cnt_clr_o = !running || done_i;
    end

    always_comb begin
        phase_d = phase_q;
        if (cancel_i) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:
                    if (rise) phase_d = on_zero_i ? PH_HELD : PH_ARMING;
                PH_ARMING:
                    if (!sig_i)      phase_d = PH_IDLE;
                    else if (done_i) phase_d = PH_HELD;
                PH_HELD:
                    if (!sig_i) phase_d = off_zero_i ? PH_IDLE : PH_RELEASE;
                PH_RELEASE:
                    if (sig_i)       phase_d = PH_HELD;
                    else if (done_i) phase_d = PH_IDLE;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            sig_d   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            sig_d   <= sig_i;
        end
    end

    always_comb begin
        phase_o = phase_q;
        level_o = phase_drives_high(phase_q);
    end

    // R2: the output only rises after the input was sampled high
    assert_rise_after_high_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(level_o) |-> $past(sig_i));

    // R3: the output only falls after a low input sample or a cancel
    assert_fall_after_low_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(level_o) |-> ($past(!sig_i) || $past(cancel_i)));

    // R4: an unqualified cycle inside an on-delay keeps the block arming
    assert_pause_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ARMING && sig_i && !qual_i && !cancel_i)
            |=> (phase_q == PH_ARMING && !level_o));

    // R5: a low input during an on-delay returns to idle
    assert_drop_discards_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ARMING && !sig_i && !cancel_i) |=> (phase_q == PH_IDLE));

    // R6: cancel forces idle with a low output
    assert_cancel_idle_R6: assert property (@(posedge clk) disable iff (rst)
        cancel_i |=> (phase_q == PH_IDLE && !level_o));

    // R7: a re-rise during an off-delay returns to a steady high
    assert_rehigh_held_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RELEASE && sig_i && !cancel_i)
            |=> (phase_q == PH_HELD && level_o));

endmodule

// File: rtl/onoff_delay_timer.sv
module onoff_delay_timer
    import odt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             pause_i,
    input  logic             cancel_i,
    input  logic             sig_i,
    input  logic [CNT_W-1:0] on_ticks_i,
    input  logic [CNT_W-1:0] off_ticks_i,
    output logic             level_o
);
    logic             qual, cnt_clr, cnt_inc, done;
    logic             on_zero, off_zero;
    logic [CNT_W-1:0] limit;
    phase_e           phase;

    always_comb begin
        on_zero  = (on_ticks_i == '0);
        off_zero = (off_ticks_i == '0);
        limit    = (phase == PH_ARMING) ? on_ticks_i : off_ticks_i;
    end

    odt_tick_gate u_gate (
        .tick_i (tick_i),
        .pause_i(pause_i),
        .qual_o (qual)
    );

    odt_tick_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .limit_i(limit),
        .done_o (done)
    );

    odt_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cancel_i  (cancel_i),
        .sig_i     (sig_i),
        .qual_i    (qual),
        .on_zero_i (on_zero),
        .off_zero_i(off_zero),
        .done_i    (done),
        .cnt_clr_o (cnt_clr),
        .cnt_inc_o (cnt_inc),
        .phase_o   (phase),
        .level_o   (level_o)
    );

    // R6: only timing phases may increment the shared counter
    assert_inc_only_timing_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_inc |-> phase_is_timing(phase));

endmodule

// File: tb/onoff_delay_timer_tb_top.sv
module onoff_delay_timer_tb_top;
    localparam int W = 16;

    logic clk = 0, rst = 1, tick = 1, pause = 0, cancel = 0, sig = 0;
    logic [W-1:0] on_t = 3, off_t = 2;
    logic level;
    int checks = 0, fails = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    onoff_delay_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .pause_i(pause),
        .cancel_i(cancel), .sig_i(sig), .on_ticks_i(on_t),
        .off_ticks_i(off_t), .level_o(level)
    );

    // behavioural reference model
    bit m_q = 0, m_prev = 0, m_busy = 0;
    int m_acc = 0;
    always @(posedge clk) begin
        bit p;
        p = m_prev;
        m_prev = rst ? 1'b0 : sig;
        if (rst || cancel) begin
            m_q = 0; m_busy = 0; m_acc = 0;
        end else if (!m_busy) begin
            if (!m_q && sig && !p) begin
                if (on_t == 0) m_q = 1; else begin m_busy = 1; m_acc = 0; end
            end else if (m_q && !sig) begin
                if (off_t == 0) m_q = 0; else begin m_busy = 1; m_acc = 0; end
            end
        end else if (sig == m_q) begin
            m_busy = 0;            // input went back: elapsed time dropped
        end else if (tick && !pause) begin
            m_acc++;
            if (m_acc >= int'(m_q ? off_t : on_t)) begin
                m_q = ~m_q; m_busy = 0;
            end
        end
    end

    always @(negedge clk) begin
        checks++;
        if (level !== m_q) begin
            fails++;
            $display("FAIL %s model compare: actual=%0b expected=%0b at %0t", cur_req, level, m_q, $time);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_to(input bit lvl, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (level !== lvl && n < 100);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        // R1: reset with input already high
        sig = 1; on_t = 2;
        edges(3);
        chk("R1 low in reset", level, 0);
        rst = 0;
        count_to(1, n);
        chk("R1 high input at release is a rise", n, 3);
        sig = 0; off_t = 0; edges(2);

        // R2 / R3 basic delays
        cur_req = "R2"; on_t = 3; off_t = 2;
        sig = 1; count_to(1, n); chk("R2 on-delay 3", n, 4);
        cur_req = "R3"; sig = 0; count_to(0, n); chk("R3 off-delay 2", n, 3);
        edges(2);
        cur_req = "R2"; on_t = 0; off_t = 0;
        sig = 1; count_to(1, n); chk("R2 on-delay 0", n, 1);
        cur_req = "R3"; sig = 0; count_to(0, n); chk("R3 off-delay 0", n, 1);
        edges(2);

        // R4 pause inside on-delay
        cur_req = "R4"; on_t = 5; off_t = 0;
        sig = 1; edges(2);
        pause = 1; edges(4);
        chk("R4 low while paused", level, 0);
        pause = 0; count_to(1, n);
        chk("R4 remaining after pause", n, 4);
        sig = 0; edges(3);

        // R5 drop during on-delay
        cur_req = "R5"; on_t = 6;
        sig = 1; edges(4);
        sig = 0; edges(1);
        chk("R5 low after drop", level, 0);
        sig = 1; count_to(1, n);
        chk("R5 full delay after drop", n, 7);
        sig = 0; edges(3);

        // R6 cancel with pause
        cur_req = "R6"; on_t = 4;
        sig = 1; edges(2);
        cancel = 1; pause = 1; edges(1);
        cancel = 0; pause = 0; edges(20);
        chk("R6 no rise after cancel", level, 0);
        sig = 0; edges(1);
        sig = 1; count_to(1, n);
        chk("R6 re-armed delay", n, 5);
        cancel = 1; edges(1);
        chk("R6 cancel drops output", level, 0);
        cancel = 0; sig = 0; edges(2);

        // R7 re-rise during off-delay
        cur_req = "R7"; on_t = 1; off_t = 4;
        sig = 1; count_to(1, n);
        sig = 0; edges(2);
        sig = 1; edges(2);
        chk("R7 stays high on re-rise", level, 1);
        sig = 0; count_to(0, n);
        chk("R7 full off-delay", n, 5);
        edges(2);

        // R8 no ticks
        cur_req = "R8"; tick = 0; on_t = 2;
        sig = 1; edges(30);
        chk("R8 no rise without ticks", level, 0);
        sig = 0; edges(2);

        // R8 random run with sparse tick, compared on every clock
        for (int i = 0; i < 3000; i++) begin
            if (i % 300 == 0) begin
                on_t = W'($urandom_range(0, 5));
                off_t = W'($urandom_range(0, 5));
            end
            tick = (i % 3 == 0);
            pause = ($urandom_range(0, 7) == 0);
            cancel = ($urandom_range(0, 63) == 0);
            if ($urandom_range(0, 5) == 0) sig = ~sig;
            edges(1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule